// File: doc/BRIEF.md
# Buffered Byte Programmer for Status-Polled NOR Flash

This block drives the command protocol of an 8-bit NOR flash whose progress is read back through a status byte, where bit 7 set means the device is ready. A client asks for one of two operations. A single-byte program writes one byte that is supplied with the request. A buffered block program writes `BLK_LEN` bytes, 32 by default, which were loaded earlier into an internal staging buffer. When the operation ends the block gives a one-cycle completion pulse and a 2-bit result code.

On the flash side there is a plain address/data bus. In every cycle the block makes at most one access: a write strobe with data, or a read strobe whose returned byte it samples on the next rising clock edge. Before it issues any command the block checks that the target bytes are erased. Each status poll is bounded by its own parameterised limit on read cycles. Every path that has issued a command ends by writing the read-array command.

Top module: `flash_buf_prog`

## Requirements
- R1: While reset is asserted, and after it, the block is idle. `busy`, `done`, `fl_we` and `fl_re` are all 0 until a request is accepted.
- R2: A single program reads the target, writes 0x40 to it, writes the data byte to it, and then reads the target every cycle until bit 7 of the returned byte is 1. It then writes 0xFF to the target and reports code 0.
- R3: A single program whose first read returns a value `v` with `(v & data) != data` ends after that one read with code 2 (not erased). It makes no write.
- R4: A block program first reads `base+i` for i = 0,1,2,... in ascending order. At the first byte that is not 0xFF it stops with code 2 and makes no write.
- R5: Once all bytes read 0xFF, the block writes 0xE8 to `base` and reads `base` until bit 7 is 1. At most `BUF_TIMEOUT_CYC` reads are made.
- R6: After the buffer becomes ready, the block writes the count `BLK_LEN-1` (0x1F) to `base`. It then writes staging entry i to `base+i` for i = 0 up to `BLK_LEN-1`, in order and one per cycle.
- R7: After the burst, the block writes 0xD0 to `base+BLK_LEN-1` and polls that same address for at most `WR_TIMEOUT_CYC` reads. It then writes 0xFF there and reports code 0.
- R8: A poll that reads bit 7 as 0 on all of its permitted reads ends with code 1 (timeout) and a 0xFF write to the polled address. Bit 7 reading 1 on the last permitted read counts as success.
- R9: `done` is a one-cycle pulse in the cycle after the final bus access, and `busy` is 0 in that cycle. `result` is 0 for success, 1 for timeout and 2 for not erased, and it holds until the next pulse.
- R10: A request or a staging-buffer load that arrives while `busy` is 1 has no effect.
- R11: `fl_we` and `fl_re` are never 1 together. In every cycle in which `busy` is 1, exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_wr_en | input | 1 | Staging-buffer load strobe (used only while idle) |
| stg_idx | input | $clog2(BLK_LEN) | Staging entry being loaded |
| stg_data | input | 8 | Byte loaded into the staging entry |
| req_valid | input | 1 | Start request (accepted only while idle) |
| req_block | input | 1 | 1 = buffered block program, 0 = single byte |
| req_addr | input | AW | Target address, or block base address |
| req_data | input | 8 | Byte for a single program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 not erased |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, sampled at the clock edge that ends a read |

## Verification
Two things can happen in the same cycle: the ready bit can arrive and the poll limit can run out. The bench sets the device's busy latency to exactly one read below the limit, and then exactly at the limit, for the single-byte wait, the buffer wait and the block completion wait. The outcome is judged from the number of status reads seen on the bus, from the address of the final 0xFF write and from the result code. In the same spirit, a staging load and a new request are driven while a block burst is running. The bench then confirms that the flash receives the original staging bytes and that no extra operation starts.

// File: rtl/flash_buf_prog_pkg.sv
package flash_buf_prog_pkg;

    localparam logic [7:0] OP_BYTE_SETUP = 8'h40;
    localparam logic [7:0] OP_BUF_SETUP  = 8'hE8;
    localparam logic [7:0] OP_COMMIT     = 8'hD0;
    localparam logic [7:0] OP_ARRAY_MODE = 8'hFF;
    localparam int         RDY_BIT       = 7;

    typedef enum logic [1:0] {
        RES_OK         = 2'd0,
        RES_TIMEOUT    = 2'd1,
        RES_NOT_ERASED = 2'd2
    } res_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S_CHK,
        ST_S_SETUP,
        ST_S_DATA,
        ST_S_POLL,
        ST_B_CHK,
        ST_B_SETUP,
        ST_B_BPOLL,
        ST_B_COUNT,
        ST_B_BURST,
        ST_B_CONF,
        ST_B_WPOLL,
        ST_RESTORE
    } st_e;

endpackage

// File: rtl/fbp_stage_buf.sv
module fbp_stage_buf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] ent_q [DEPTH];
    logic [DW-1:0] ent_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (wr_en && (wr_idx == IW'(g))) begin
                ent_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            ent_q[g] <= ent_d[g];
        end
    end

    assign rd_data = ent_q[rd_idx];

endmodule

// File: rtl/fbp_poll_timer.sv
module fbp_poll_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          last
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == (limit - 1'b1));

    // R8: the counter never runs past the last permitted poll
    p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !clr) |-> !step);

endmodule

// File: rtl/flash_buf_prog.sv
module flash_buf_prog
    import flash_buf_prog_pkg::*;
#(
    parameter int AW              = 16,
    parameter int BLK_LEN         = 32,
    parameter int WR_TIMEOUT_CYC  = 4096,
    parameter int BUF_TIMEOUT_CYC = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       stg_wr_en,
    input  logic [$clog2(BLK_LEN)-1:0] stg_idx,
    input  logic [7:0]                 stg_data,
    input  logic                       req_valid,
    input  logic                       req_block,
    input  logic [AW-1:0]              req_addr,
    input  logic [7:0]                 req_data,
    output logic                       busy,
    output logic                       done,
    output logic [1:0]                 result,
    output logic [AW-1:0]              fl_addr,
    output logic [7:0]                 fl_wdata,
    output logic                       fl_we,
    output logic                       fl_re,
    input  logic [7:0]                 fl_rdata
);

    localparam int IW     = $clog2(BLK_LEN);
    localparam int MAX_TO = (WR_TIMEOUT_CYC > BUF_TIMEOUT_CYC) ? WR_TIMEOUT_CYC : BUF_TIMEOUT_CYC;
    localparam int CW     = $clog2(MAX_TO + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(BLK_LEN - 1);

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] base;
        logic [IW-1:0] idx;
        logic [7:0]    sdata;
        res_e          pend;
        res_e          res;
        logic          done;
    } ctl_t;

    ctl_t q, n;

    logic          tmr_clr, tmr_step, tmr_wr, tmr_last;
    logic [7:0]    stg_rd;
    logic          ready;

    fbp_stage_buf #(.DEPTH(BLK_LEN), .DW(8)) u_buf (
        .clk     (clk),
        .wr_en   (stg_wr_en && (q.st == ST_IDLE)),
        .wr_idx  (stg_idx),
        .wr_data (stg_data),
        .rd_idx  (q.idx),
        .rd_data (stg_rd)
    );

    fbp_poll_timer #(.CW(CW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .step  (tmr_step),
        .limit (tmr_wr ? CW'(WR_TIMEOUT_CYC) : CW'(BUF_TIMEOUT_CYC)),
        .last  (tmr_last)
    );

    assign ready = fl_rdata[RDY_BIT];

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_wdata = 8'h00;
        tmr_clr  = 1'b1;
        tmr_step = 1'b0;
        tmr_wr   = 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    n.base  = req_addr;
                    n.idx   = '0;
                    n.sdata = req_data;
                    n.st    = req_block ? ST_B_CHK : ST_S_CHK;
                end
            end
            ST_S_CHK: begin
                fl_re = 1'b1;
                if ((fl_rdata & q.sdata) != q.sdata) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                    n.res  = RES_NOT_ERASED;
                end else begin
                    n.st = ST_S_SETUP;
                end
            end
            ST_S_SETUP: begin
                fl_we    = 1'b1;
                fl_wdata = OP_BYTE_SETUP;
                n.st     = ST_S_DATA;
            end
            ST_S_DATA: begin
                fl_we    = 1'b1;
                fl_wdata = q.sdata;
                n.st     = ST_S_POLL;
            end
            ST_S_POLL, ST_B_WPOLL: begin
                fl_re   = 1'b1;
                tmr_clr = 1'b0;
                if (ready) begin
                    n.pend = RES_OK;
                    n.st   = ST_RESTORE;
                end else if (tmr_last) begin
                    n.pend = RES_TIMEOUT;
                    n.st   = ST_RESTORE;
                end else begin
                    tmr_step = 1'b1;
                end
            end
            ST_B_CHK: begin
                fl_re = 1'b1;
                if (fl_rdata != 8'hFF) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                    n.res  = RES_NOT_ERASED;
                end else if (q.idx == LAST_IDX) begin
                    n.idx = '0;
                    n.st  = ST_B_SETUP;
                end else begin
                    n.idx = q.idx + 1'b1;
                end
            end
            ST_B_SETUP: begin
                fl_we    = 1'b1;
                fl_wdata = OP_BUF_SETUP;
                n.st     = ST_B_BPOLL;
            end
            ST_B_BPOLL: begin
                fl_re   = 1'b1;
                tmr_clr = 1'b0;
                tmr_wr  = 1'b0;
                if (ready) begin
                    n.st = ST_B_COUNT;
                end else if (tmr_last) begin
                    n.pend = RES_TIMEOUT;
                    n.st   = ST_RESTORE;
                end else begin
                    tmr_step = 1'b1;
                end
            end
            ST_B_COUNT: begin
                fl_we    = 1'b1;
                fl_wdata = 8'(BLK_LEN - 1);
                n.st     = ST_B_BURST;
            end
            ST_B_BURST: begin
                fl_we    = 1'b1;
                fl_wdata = stg_rd;
                if (q.idx == LAST_IDX) begin
                    n.st = ST_B_CONF;
                end else begin
                    n.idx = q.idx + 1'b1;
                end
            end
            ST_B_CONF: begin
                fl_we    = 1'b1;
                fl_wdata = OP_COMMIT;
                n.st     = ST_B_WPOLL;
            end
            ST_RESTORE: begin
                fl_we    = 1'b1;
                fl_wdata = OP_ARRAY_MODE;
                n.st     = ST_IDLE;
                n.done   = 1'b1;
                n.res    = q.pend;
            end
            default: begin
                n.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.base  <= '0;
            q.idx   <= '0;
            q.sdata <= '0;
            q.pend  <= RES_OK;
            q.res   <= RES_OK;
            q.done  <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign fl_addr = q.base + AW'(q.idx);
    assign busy    = (q.st != ST_IDLE);
    assign done    = q.done;
    assign result  = q.res;

    // R11: one bus access per cycle, never both strobes
    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));
    // R11: a busy cycle always carries an access
    p_busy_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (fl_we || fl_re));
    // R9: completion is a single-cycle pulse that follows a busy cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R3/R4: a not-erased exit comes straight after a read, no write issued
    p_nerase_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_NOT_ERASED) |-> $past(fl_re));
    // R8: all other exits end with the read-array command
    p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != RES_NOT_ERASED) |-> $past(fl_we && fl_wdata == OP_ARRAY_MODE));
    // R9: result changes only with a completion pulse
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

// File: tb/flash_buf_prog_tb.sv
module flash_buf_prog_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 8;
    localparam int BL  = 32;
    localparam int WTO = 10;
    localparam int BTO = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stg_wr_en = 1'b0;
    logic [4:0] stg_idx = '0;
    logic [7:0] stg_data = '0;
    logic       req_valid = 1'b0;
    logic       req_block = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       busy, done, fl_we, fl_re;
    logic [1:0] result;
    logic [7:0] fl_addr, fl_wdata, fl_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_buf_prog #(.AW(AW), .BLK_LEN(BL), .WR_TIMEOUT_CYC(WTO), .BUF_TIMEOUT_CYC(BTO)) u_dut (
        .clk(clk), .rst_n(rst_n), .stg_wr_en(stg_wr_en), .stg_idx(stg_idx), .stg_data(stg_data),
        .req_valid(req_valid), .req_block(req_block), .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .done(done), .result(result), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
    );

    // behavioural flash device
    logic [7:0] fmem [256];
    bit stat_mode = 0, prog_next = 0, cnt_next = 0;
    int blk_left = 0, busy_left = 0;
    int wr_lat = 0, buf_lat = 0;

    assign fl_rdata = stat_mode ? ((busy_left == 0) ? 8'h80 : 8'h00) : fmem[fl_addr];

    always @(posedge clk) begin
        if (fl_re && stat_mode && busy_left > 0) busy_left <= busy_left - 1;
        if (fl_we) begin
            if (prog_next) begin
                fmem[fl_addr] <= fmem[fl_addr] & fl_wdata;
                prog_next <= 0; stat_mode <= 1; busy_left <= wr_lat;
            end else if (blk_left > 0) begin
                fmem[fl_addr] <= fmem[fl_addr] & fl_wdata;
                blk_left <= blk_left - 1;
            end else if (cnt_next && fl_wdata != 8'hFF) begin
                blk_left <= int'(fl_wdata) + 1; cnt_next <= 0;
            end else begin
                case (fl_wdata)
                    8'h40: prog_next <= 1;
                    8'hE8: begin stat_mode <= 1; busy_left <= buf_lat; cnt_next <= 1; end
                    8'hD0: begin stat_mode <= 1; busy_left <= wr_lat; end
                    8'hFF: begin stat_mode <= 0; cnt_next <= 0; end
                    default: ;
                endcase
            end
        end
    end

    // reference: expected bus accesses {we, addr, data}
    logic [16:0] exp_q [$];
    logic [1:0]  exp_res;
    logic [7:0]  stg_m [BL];
    int vecs = 0, fails = 0;
    bit running = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && running) begin
            logic [16:0] act, e;
            act = fl_we ? {1'b1, fl_addr, fl_wdata} : {1'b0, fl_addr, 8'h00};
            chk(!(fl_we && fl_re), "R11 strobes", {fl_we, fl_re}, 0);
            if (busy) begin
                chk(fl_we || fl_re, "R11 access", 0, 1);
                if (exp_q.size() == 0) begin
                    chk(0, "R2/R6 extra access", int'(act), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(act == e, "R2-R7 access", int'(act), int'(e));
                end
            end else begin
                chk(!fl_we && !fl_re, "R11 idle bus", {fl_we, fl_re}, 0);
            end
            if (done) begin
                chk(result == exp_res, "R9 result", result, exp_res);
                chk(exp_q.size() == 0, "R9 early done", exp_q.size(), 0);
            end
        end
    end

    task automatic push_op(input bit we, input logic [7:0] a, input logic [7:0] d);
        exp_q.push_back({we, a, d});
    endtask

    task automatic launch(input bit blk, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1; req_block = blk; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_single(input logic [7:0] a, input logic [7:0] d, input int lat);
        int k;
        wr_lat = lat;
        push_op(0, a, 0);
        if ((fmem[a] & d) != d) begin
            exp_res = 2;
        end else begin
            push_op(1, a, 8'h40);
            push_op(1, a, d);
            k = (lat < WTO) ? lat + 1 : WTO;
            for (int i = 0; i < k; i++) push_op(0, a, 0);
            push_op(1, a, 8'hFF);
            exp_res = (lat < WTO) ? 2'd0 : 2'd1;
        end
        launch(0, a, d);
    endtask

    task automatic predict_block(input logic [7:0] a, input int bl, input int wl);
        int bad, k;
        buf_lat = bl; wr_lat = wl; bad = -1;
        for (int i = 0; i < BL; i++) begin
            push_op(0, 8'(a + i), 0);
            if (fmem[8'(a + i)] != 8'hFF) begin bad = i; break; end
        end
        if (bad >= 0) begin
            exp_res = 2;
        end else begin
            push_op(1, a, 8'hE8);
            k = (bl < BTO) ? bl + 1 : BTO;
            for (int i = 0; i < k; i++) push_op(0, a, 0);
            if (bl >= BTO) begin
                push_op(1, a, 8'hFF);
                exp_res = 1;
            end else begin
                push_op(1, a, 8'h1F);
                for (int i = 0; i < BL; i++) push_op(1, 8'(a + i), stg_m[i]);
                push_op(1, 8'(a + BL - 1), 8'hD0);
                k = (wl < WTO) ? wl + 1 : WTO;
                for (int i = 0; i < k; i++) push_op(0, 8'(a + BL - 1), 0);
                push_op(1, 8'(a + BL - 1), 8'hFF);
                exp_res = (wl < WTO) ? 2'd0 : 2'd1;
            end
        end
    endtask

    task automatic do_block(input logic [7:0] a, input int bl, input int wl);
        predict_block(a, bl, wl);
        launch(1, a, 8'h00);
    endtask

    task automatic chk_block_mem(input logic [7:0] a, input string tag);
        for (int i = 0; i < BL; i++)
            chk(fmem[8'(a + i)] == stg_m[i], tag, fmem[8'(a + i)], stg_m[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) fmem[i] <= 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !fl_we && !fl_re, "R1 reset", {busy, done, fl_we, fl_re}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !fl_we && !fl_re, "R1 after reset", {busy, done, fl_we, fl_re}, 0);
        running = 1;

        for (int i = 0; i < BL; i++) begin
            stg_m[i] = 8'(i * 37 + 11);
            stg_wr_en = 1; stg_idx = 5'(i); stg_data = stg_m[i];
            @(negedge clk);
        end
        stg_wr_en = 0;

        // R2: plain single program
        do_single(8'h10, 8'h5A, 3);
        chk(fmem[8'h10] == 8'h5A, "R2 data", fmem[8'h10], 8'h5A);
        // R3: not erased for this data
        do_single(8'h10, 8'hA5, 0);
        chk(fmem[8'h10] == 8'h5A, "R3 untouched", fmem[8'h10], 8'h5A);
        // R2: clears only bits, allowed over programmed byte
        do_single(8'h10, 8'h12, 0);
        chk(fmem[8'h10] == 8'h12, "R2 subset", fmem[8'h10], 8'h12);
        // R8: ready on last permitted read, then one read too late
        do_single(8'h11, 8'h33, WTO - 1);
        do_single(8'h12, 8'h44, WTO);

        // R4 R5 R6 R7: full block program
        do_block(8'h40, 2, 4);
        chk_block_mem(8'h40, "R6 burst data");
        // R4: first byte already programmed
        do_block(8'h40, 0, 0);
        // R4: bad byte in the middle
        fmem[8'h94] <= 8'h00;
        @(negedge clk);
        do_block(8'h80, 0, 0);
        // R8: buffer wait timeout, then ready on last permitted read
        do_block(8'h60, BTO, 0);
        do_block(8'hA0, BTO - 1, WTO - 1);
        chk_block_mem(8'hA0, "R5 boundary data");
        // R8: completion timeout restores at last address
        do_block(8'hC0, 0, WTO);

        // R10: load and request while busy are ignored
        predict_block(8'hE0, 1, 2);
        @(negedge clk);
        req_valid = 1; req_block = 1; req_addr = 8'hE0;
        @(negedge clk);
        req_valid = 0;
        repeat (40) @(negedge clk);
        stg_wr_en = 1; stg_idx = 5'd20; stg_data = 8'h00;
        req_valid = 1; req_block = 0; req_addr = 8'h05; req_data = 8'h00;
        @(negedge clk);
        stg_wr_en = 0; req_valid = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk_block_mem(8'hE0, "R10 staging kept");
        chk(fmem[8'h05] == 8'hFF, "R10 request ignored", fmem[8'h05], 8'hFF);
        repeat (3) @(negedge clk);
        chk(!busy, "R10 no extra op", busy, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule